// File: doc/BRIEF.md
# Folded Integration Value Reconstructor

An integrating pixel that bounces between two reference levels leaves behind two pieces of information once its exposure ends: how many times the ramp turned around (the bounce count) and where the ramp finally stopped, measured from the lower reference (the residual code, already digitised). The ramp rises on even-numbered legs and falls on odd-numbered legs, so the final value is a triangle-folded version of a straight line. This block unfolds it and rebuilds the linear value that the integration would have reached if the voltage swing had no ceiling.

The span between the two references is a fixed digital code, `DV_CODE`. For an even bounce count the residual is added on top of the completed spans. For an odd bounce count it is subtracted from the span above. A pixel whose counter ran out is marked through a saturation input. It leaves the block flagged and pinned at the full-scale code, so a saturated pixel can never look dark. Each result appears one clock after its input strobe.

Top module: `fold_recon`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_vld`, `out_sat` and `out_value` are all zero until the first accepted input.
- R2: `out_vld` is high in exactly the cycle after a cycle in which `in_vld` was high. The result it qualifies belongs to that input.
- R3: For an even bounce count k (bit 0 of `in_bounce` is 0) with `in_max` low, `out_value` = `DV_CODE`·k + residual.
- R4: For an odd bounce count k (bit 0 of `in_bounce` is 1) with `in_max` low, `out_value` = `DV_CODE`·(k+1) − residual.
- R5: With k = 0 and `in_max` low, `out_value` equals the residual alone.
- R6: A residual code above `DV_CODE` is treated as `DV_CODE` before it is folded.
- R7: With `in_max` high, `out_sat` is 1 and `out_value` is the full-scale code `DV_CODE`·(2^`CNT_W`+1). With `in_max` low, `out_sat` is 0.
- R8: `out_value` never exceeds the full-scale code, for any input.
- R9: In a cycle with `in_vld` low, the inputs are ignored: `out_value` and `out_sat` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input strobe, one pixel per high cycle |
| in_bounce | input | CNT_W | Bounce count k |
| in_max | input | 1 | Counter saturation flag of the pixel |
| in_resid | input | RES_W | Residual code above the lower reference |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_value | output | OUT_W | Unfolded linear value |
| out_sat | output | 1 | Pixel saturated |

## Verification
The unfolding is tried with even and odd bounce counts at both ends of the residual range (zero and exactly `DV_CODE`). This separates the add leg from the subtract leg and shows that neighbouring legs meet at the same code. Zero-bounce inputs isolate the pass-through case, and residuals above the span test the clamp on both parities. The largest odd count and the largest even count stress the output width, and saturated inputs with arbitrary counts and residuals confirm that the flag overrides everything else. Idle cycles with changing inputs show that nothing is taken in without the strobe.

// File: rtl/fold_recon_pkg.sv
package fold_recon_pkg;

  // Unfold one triangle-folded sample.
  // Even leg: completed spans plus the rise on the current leg.
  // Odd leg: the span above minus the fall on the current leg.
  function automatic logic [63:0] unfold_code(input logic [63:0] bounces,
                                              input logic [63:0] resid,
                                              input logic [63:0] span);
    logic [63:0] legs_up;
    if (bounces[0]) begin
      legs_up = bounces + 64'd1;
      return span * legs_up - resid;
    end
    return span * bounces + resid;
  endfunction

  // Limit a residual to the span.
  function automatic logic [63:0] limit_code(input logic [63:0] resid,
                                             input logic [63:0] span);
    return (resid > span) ? span : resid;
  endfunction

  // Largest code the output must hold.
  function automatic logic [63:0] full_scale(input int unsigned cnt_w,
                                             input int unsigned span);
    return 64'(span) * ((64'd1 << cnt_w) + 64'd1);
  endfunction

endpackage

// File: rtl/fold_resid_clamp.sv
module fold_resid_clamp #(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned DV_CODE = 2000
) (
  input  logic [RES_W-1:0] resid_raw,
  output logic [RES_W-1:0] resid_lim,
  output logic             resid_over
);
  import fold_recon_pkg::*;

  localparam logic [RES_W-1:0] SPAN_R = RES_W'(DV_CODE);

  logic [63:0] lim_wide;

  assign resid_over = (resid_raw > SPAN_R);
  assign lim_wide   = limit_code(64'(resid_raw), 64'(SPAN_R));
  assign resid_lim  = RES_W'(lim_wide);
endmodule

// File: rtl/fold_unfold.sv
module fold_unfold #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RES_W   = 12,
  parameter int unsigned OUT_W   = 19,
  parameter int unsigned DV_CODE = 2000
) (
  input  logic [CNT_W-1:0] bounces,
  input  logic             sat_flag,
  input  logic [RES_W-1:0] resid,
  output logic [OUT_W-1:0] value,
  output logic             odd_leg
);
  import fold_recon_pkg::*;

  localparam logic [63:0] FULL64 = full_scale(CNT_W, DV_CODE);
  localparam logic [OUT_W-1:0] FULL_CODE = OUT_W'(FULL64);

  logic [63:0]      unfold_wide;
  logic [OUT_W-1:0] unfold_val;

  assign odd_leg     = bounces[0];
  assign unfold_wide = unfold_code(64'(bounces), 64'(resid), 64'(DV_CODE));
  assign unfold_val  = OUT_W'(unfold_wide);
  assign value       = sat_flag ? FULL_CODE : unfold_val;
endmodule

// File: rtl/fold_result_reg.sv
module fold_result_reg #(
  parameter int unsigned OUT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] value_d,
  input  logic             sat_d,
  output logic             vld_q,
  output logic [OUT_W-1:0] value_q,
  output logic             sat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      value_q <= '0;
      sat_q   <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        value_q <= value_d;
        sat_q   <= sat_d;
      end
    end
  end
endmodule

// File: rtl/fold_recon.sv
module fold_recon #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RES_W   = 12,
  parameter int unsigned DV_CODE = 2000,
  parameter int unsigned OUT_W   =
    $clog2(DV_CODE * ((1 << CNT_W) + 1) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [CNT_W-1:0] in_bounce,
  input  logic             in_max,
  input  logic [RES_W-1:0] in_resid,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_value,
  output logic             out_sat
);
  // Internal events brought out as named wires for the checker.
  logic [RES_W-1:0] resid_lim;
  logic             resid_over;
  logic             odd_leg;
  logic [OUT_W-1:0] value_next;

  fold_resid_clamp #(
    .RES_W  (RES_W),
    .DV_CODE(DV_CODE)
  ) u_clamp (
    .resid_raw (in_resid),
    .resid_lim (resid_lim),
    .resid_over(resid_over)
  );

  fold_unfold #(
    .CNT_W  (CNT_W),
    .RES_W  (RES_W),
    .OUT_W  (OUT_W),
    .DV_CODE(DV_CODE)
  ) u_unfold (
    .bounces (in_bounce),
    .sat_flag(in_max),
    .resid   (resid_lim),
    .value   (value_next),
    .odd_leg (odd_leg)
  );

  fold_result_reg #(
    .OUT_W(OUT_W)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_vld),
    .value_d(value_next),
    .sat_d  (in_max),
    .vld_q  (out_vld),
    .value_q(out_value),
    .sat_q  (out_sat)
  );
endmodule

// File: rtl/fold_recon_chk.sv
module fold_recon_chk #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RES_W   = 12,
  parameter int unsigned DV_CODE = 2000,
  parameter int unsigned OUT_W   = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [CNT_W-1:0] in_bounce,
  input logic             in_max,
  input logic [RES_W-1:0] in_resid,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_value,
  input logic             out_sat,
  input logic             resid_over,
  input logic             odd_leg
);
  localparam logic [OUT_W-1:0] FULL_C = OUT_W'(64'(DV_CODE) * ((64'd1 << CNT_W) + 64'd1));
  localparam logic [OUT_W-1:0] SPAN_C = OUT_W'(DV_CODE);

  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  a_r5_zero_bounce: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_max && in_bounce == '0 && !resid_over)
      |=> out_value == OUT_W'($past(in_resid)));
  a_r6_clamp_even: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_max && in_bounce == '0 && resid_over) |=> out_value == SPAN_C);
  a_r4_odd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_max && odd_leg) |=> out_value != '0);
  a_r7_sat_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_max) |=> (out_sat && out_value == FULL_C));
  a_r7_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_max) |=> !out_sat);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_value <= FULL_C);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_value) && $stable(out_sat)));
endmodule

bind fold_recon fold_recon_chk #(
  .CNT_W  (CNT_W),
  .RES_W  (RES_W),
  .DV_CODE(DV_CODE),
  .OUT_W  (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .in_bounce (in_bounce),
  .in_max    (in_max),
  .in_resid  (in_resid),
  .out_vld   (out_vld),
  .out_value (out_value),
  .out_sat   (out_sat),
  .resid_over(resid_over),
  .odd_leg   (odd_leg)
);

// File: tb/sim_fold_recon.sv
`timescale 1ns/1ps
module sim_fold_recon;
  localparam int CNT_W = 8;
  localparam int RES_W = 12;
  localparam int DV    = 2000;
  localparam int OUT_W = $clog2(DV * ((1 << CNT_W) + 1) + 1);
  localparam int FULL  = DV * ((1 << CNT_W) + 1);
  localparam int NV    = 14;

  // Columns: bounce count, max flag, residual, expected value, requirement number.
  localparam int VK  [NV] = '{0, 0,    2,   1,   1,    3,    4,    0,    5,      255,    254,   10,  255,  7};
  localparam int VM  [NV] = '{0, 0,    0,   0,   0,    0,    0,    0,    0,      0,      0,     1,   1,    0};
  localparam int VR  [NV] = '{0, 1234, 500, 500, 0,    2000, 2000, 3000, 4095,   7,      2000,  100, 4095, 2000};
  localparam int VE  [NV] = '{0, 1234, 4500,3500,4000, 6000, 10000,2000, 10000,  511993, 510000,FULL,FULL, 14000};
  localparam int VQ  [NV] = '{5, 5,    3,   4,   4,    4,    3,    6,    6,      4,      3,     7,   7,    4};
  // R5 rows 0-1, R3 rows 2,6,10, R4 rows 3-5,9,13, R6 rows 7-8, R7 rows 11-12,
  // R8 rows 9-12 (largest codes).

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [CNT_W-1:0] in_bounce = '0;
  logic             in_max = 1'b0;
  logic [RES_W-1:0] in_resid = '0;
  logic             out_vld;
  logic [OUT_W-1:0] out_value;
  logic             out_sat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fold_recon #(.CNT_W(CNT_W), .RES_W(RES_W), .DV_CODE(DV)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bounce(in_bounce),
    .in_max(in_max), .in_resid(in_resid), .out_vld(out_vld),
    .out_value(out_value), .out_sat(out_sat));

  task automatic check(input int req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int k, input int m, input int r);
    @(negedge clk);
    in_vld    = 1'b1;
    in_bounce = CNT_W'(k);
    in_max    = m[0];
    in_resid  = RES_W'(r);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state.
    repeat (3) @(posedge clk);
    #1;
    check(1, int'(out_vld), 0, "vld in reset");
    check(1, int'(out_value), 0, "value in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, int'(out_vld), 0, "vld after reset");
    check(1, int'(out_sat), 0, "sat after reset");

    // Vector table, applied back to back.
    for (int i = 0; i < NV; i++) begin
      apply(VK[i], VM[i], VR[i]);
      check(2, int'(out_vld), 1, "strobe");
      check(VQ[i], int'(out_value), VE[i], $sformatf("value row %0d", i));
      check(7, int'(out_sat), VM[i], $sformatf("sat row %0d", i));
      check(8, int'(out_value <= OUT_W'(FULL)), 1, "within full scale");
    end

    // R9: idle cycles with changing inputs leave the output alone.
    @(negedge clk);
    in_vld = 1'b0; in_bounce = 8'd3; in_max = 1'b1; in_resid = 12'd9;
    @(posedge clk); #1;
    check(2, int'(out_vld), 0, "strobe drops");
    @(negedge clk);
    in_bounce = 8'd100; in_max = 1'b0; in_resid = 12'd1;
    @(posedge clk); #1;
    check(9, int'(out_value), 14000, "value held");
    check(9, int'(out_sat), 0, "sat held");

    // R7 then R9: saturated value held through idle cycles.
    apply(0, 1, 0);
    check(7, int'(out_value), FULL, "sat overrides zero count");
    @(negedge clk) in_vld = 1'b0; in_max = 1'b0;
    repeat (2) @(posedge clk); #1;
    check(9, int'(out_sat), 1, "sat held while idle");

    // R3/R4: adjacent legs meet at the same code.
    apply(6, 0, 2000);
    check(3, int'(out_value), 14000, "even leg top");
    apply(7, 0, 2000);
    check(4, int'(out_value), 14000, "odd leg start");

    // R1: reset in mid-run clears everything.
    @(negedge clk) in_vld = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    check(1, int'(out_value), 0, "value after second reset");
    check(1, int'(out_vld), 0, "vld after second reset");

    done = 1'b1;
    finish_run();
  end
endmodule